// File: doc/BRIEF.md
# Write-First Dual-Port Memory with Collision Flags

This block is a synchronous memory with two ports, A and B. Each port has its own clock, enable, write enable, output reset, address, input data and output data, and each can read or write on its own. Every input of a port is captured on the rising edge of that port's clock. A write shows the stored value on the writing port's output on the same edge. A disabled port keeps its output unchanged.

When the two ports share one clock (the `COMMON_CLK` parameter, default 1), the block compares what both ports do on each edge. If one port writes an address while the other reads that address, the write completes and the reading port raises its data-invalid flag together with its output. If both ports write the same address, the word is marked corrupt. Any later read of that word raises the reader's flag until a later write from a single port repairs it. When `COMMON_CLK` is 0 the ports run on independent clocks and no collision flag is ever raised.

The block is used as a shared buffer between two agents. Each agent treats an output with its invalid flag raised as data it must discard.

Top module: `wf_dpram`

## Requirements
- R1: A port with enable 1, write enable 0 and reset 0 at a rising edge presents the addressed word on its output after that edge.
- R2: A port with enable 1 and write enable 1 at a rising edge stores its input data at the address. After that edge its output equals that input data and its invalid flag is 0.
- R3: While enable is 0, a port's output and invalid flag hold their values, and its write enable, address and data have no effect on memory.
- R4: Reset 1 together with enable 1 sets that port's output to 0 and its invalid flag to 0. Reset does not alter memory, and a write issued with reset still stores its data. Reset with enable 0 has no effect.
- R5: From power-up until the first enabled edge, both outputs and both invalid flags are 0.
- R6: With a common clock, if one port writes an address on the same edge that the other port reads it, the write is stored and the writer's flag is 0, while the reader's invalid flag is 1.
- R7: With a common clock, if both ports write the same address on one edge, that word is marked corrupt. Every later read of it raises the reading port's invalid flag.
- R8: A write to a corrupt word from one port alone clears the mark. A later read returns the new data with the flag at 0.
- R9: Two reads of the same address on one edge never raise a flag, and both ports return the stored word.
- R10: A port's output does not follow a write made by the other port to the address it last read. The new value appears only on that port's next read.
- R11: Writes from both ports on one edge to different addresses store both words and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| rst_a | input | 1 | Port A synchronous output reset, active high |
| addr_a | input | ADDR_W | Port A word address |
| din_a | input | DATA_W | Port A write data |
| dout_a | output | DATA_W | Port A registered output data |
| dinv_a | output | 1 | Port A output-data-invalid flag |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| rst_b | input | 1 | Port B synchronous output reset, active high |
| addr_b | input | ADDR_W | Port B word address |
| din_b | input | DATA_W | Port B write data |
| dout_b | output | DATA_W | Port B registered output data |
| dinv_b | output | 1 | Port B output-data-invalid flag |

## Verification
The hardest situation to reach is a collision: both ports must target one address on the very same edge, and the corruption left by a double write cannot be seen when it happens. The bench drives both port clocks from one clock and sets up both ports together in the window before a shared edge. It then looks for the corruption mark through a later read of that word on each port. After that it repairs the word with a write from a single port and reads it back.

// File: rtl/wfr_pkg.sv
package wfr_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } port_op_e;

  function automatic port_op_e decode_op(input logic en, input logic we);
    if (!en)     return OP_IDLE;
    else if (we) return OP_WRITE;
    else         return OP_READ;
  endfunction

endpackage

// File: rtl/wfr_collide.sv
module wfr_collide #(
  parameter int ADDR_W = 8
) (
  input  logic              en_a,
  input  logic              we_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic              en_b,
  input  logic              we_b,
  input  logic [ADDR_W-1:0] addr_b,
  output logic              ww_hit,
  output logic              a_rd_hit,
  output logic              b_rd_hit
);
  import wfr_pkg::*;

  port_op_e op_a, op_b;
  logic     same;

  always_comb begin
    op_a     = decode_op(en_a, we_a);
    op_b     = decode_op(en_b, we_b);
    same     = (addr_a == addr_b);
    ww_hit   = same && (op_a == OP_WRITE) && (op_b == OP_WRITE);
    a_rd_hit = same && (op_a == OP_READ)  && (op_b == OP_WRITE);
    b_rd_hit = same && (op_b == OP_READ)  && (op_a == OP_WRITE);
  end
endmodule

// File: rtl/wfr_store_shared.sv
module wfr_store_shared #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] din_a,
  input  logic              wr_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] din_b,
  input  logic              ww_hit,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  output logic              ri_a,
  output logic              ri_b
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              bad [DEPTH] = '{default: 1'b0};

  always_ff @(posedge clk) begin
    if (wr_a) mem[addr_a] <= din_a;
    if (wr_b && !ww_hit) mem[addr_b] <= din_b;
  end

  always_ff @(posedge clk) begin
    if (ww_hit) begin
      bad[addr_a] <= 1'b1;
    end else begin
      if (wr_a) bad[addr_a] <= 1'b0;
      if (wr_b) bad[addr_b] <= 1'b0;
    end
  end

  assign rd_a = mem[addr_a];
  assign rd_b = mem[addr_b];
  assign ri_a = bad[addr_a];
  assign ri_b = bad[addr_b];
endmodule

// File: rtl/wfr_store_split.sv
module wfr_store_split #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_a,
  input  logic              wr_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] din_a,
  input  logic              clk_b,
  input  logic              wr_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] din_b,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_a) begin
    if (wr_a) mem[addr_a] <= din_a;
  end

  always_ff @(posedge clk_b) begin
    if (wr_b) mem[addr_b] <= din_b;
  end

  assign rd_a = mem[addr_a];
  assign rd_b = mem[addr_b];
endmodule

// File: rtl/wfr_oport.sv
module wfr_oport #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_bad,
  input  logic              coll,
  output logic [DATA_W-1:0] dout,
  output logic              dinv
);
  import wfr_pkg::*;

  logic [DATA_W-1:0] dout_q = '0;
  logic              dinv_q = 1'b0;
  port_op_e          op;

  assign op = decode_op(en, we);

  always_ff @(posedge clk) begin
    if (op != OP_IDLE) begin
      if (rst) begin
        dout_q <= '0;
        dinv_q <= 1'b0;
      end else if (op == OP_WRITE) begin
        dout_q <= din;
        dinv_q <= 1'b0;
      end else begin
        dout_q <= rd_data;
        dinv_q <= rd_bad | coll;
      end
    end
  end

  assign dout = dout_q;
  assign dinv = dinv_q;
endmodule

// File: rtl/wf_dpram.sv
module wf_dpram #(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 256,
  parameter bit COMMON_CLK = 1'b1,
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk_a,
  input  logic              en_a,
  input  logic              we_a,
  input  logic              rst_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] din_a,
  output logic [DATA_W-1:0] dout_a,
  output logic              dinv_a,
  input  logic              clk_b,
  input  logic              en_b,
  input  logic              we_b,
  input  logic              rst_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] din_b,
  output logic [DATA_W-1:0] dout_b,
  output logic              dinv_b
);
  logic              wr_a, wr_b;
  logic              ww_hit, a_rd_hit, b_rd_hit;
  logic [DATA_W-1:0] rd_a, rd_b;
  logic              ri_a, ri_b;

  assign wr_a = en_a & we_a;
  assign wr_b = en_b & we_b;

  generate
    if (COMMON_CLK) begin : g_shared
      wfr_collide #(.ADDR_W(ADDR_W)) u_coll (
        .en_a(en_a), .we_a(we_a), .addr_a(addr_a),
        .en_b(en_b), .we_b(we_b), .addr_b(addr_b),
        .ww_hit(ww_hit), .a_rd_hit(a_rd_hit), .b_rd_hit(b_rd_hit)
      );
      wfr_store_shared #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk_a),
        .wr_a(wr_a), .addr_a(addr_a), .din_a(din_a),
        .wr_b(wr_b), .addr_b(addr_b), .din_b(din_b),
        .ww_hit(ww_hit),
        .rd_a(rd_a), .rd_b(rd_b), .ri_a(ri_a), .ri_b(ri_b)
      );
    end else begin : g_split
      assign ww_hit   = 1'b0;
      assign a_rd_hit = 1'b0;
      assign b_rd_hit = 1'b0;
      assign ri_a     = 1'b0;
      assign ri_b     = 1'b0;
      wfr_store_split #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk_a(clk_a), .wr_a(wr_a), .addr_a(addr_a), .din_a(din_a),
        .clk_b(clk_b), .wr_b(wr_b), .addr_b(addr_b), .din_b(din_b),
        .rd_a(rd_a), .rd_b(rd_b)
      );
    end
  endgenerate

  wfr_oport #(.DATA_W(DATA_W)) u_port_a (
    .clk(clk_a), .en(en_a), .we(we_a), .rst(rst_a), .din(din_a),
    .rd_data(rd_a), .rd_bad(ri_a), .coll(a_rd_hit),
    .dout(dout_a), .dinv(dinv_a)
  );

  wfr_oport #(.DATA_W(DATA_W)) u_port_b (
    .clk(clk_b), .en(en_b), .we(we_b), .rst(rst_b), .din(din_b),
    .rd_data(rd_b), .rd_bad(ri_b), .coll(b_rd_hit),
    .dout(dout_b), .dinv(dinv_b)
  );
endmodule

// File: rtl/wf_dpram_chk.sv
module wf_dpram_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk_a,
  input logic              en_a,
  input logic              we_a,
  input logic              rst_a,
  input logic [DATA_W-1:0] din_a,
  input logic [DATA_W-1:0] dout_a,
  input logic              dinv_a,
  input logic              clk_b,
  input logic              en_b,
  input logic              we_b,
  input logic              rst_b,
  input logic [DATA_W-1:0] din_b,
  input logic [DATA_W-1:0] dout_b,
  input logic              dinv_b
);
  AST_HOLD_A: assert property (@(posedge clk_a) disable iff (rst_a)
    !en_a |=> ($stable(dout_a) && $stable(dinv_a))); // R3
  AST_HOLD_B: assert property (@(posedge clk_b) disable iff (rst_b)
    !en_b |=> ($stable(dout_b) && $stable(dinv_b))); // R3
  AST_ECHO_A: assert property (@(posedge clk_a) disable iff (rst_a)
    (en_a && we_a) |=> (dout_a == $past(din_a) && !dinv_a)); // R2
  AST_ECHO_B: assert property (@(posedge clk_b) disable iff (rst_b)
    (en_b && we_b) |=> (dout_b == $past(din_b) && !dinv_b)); // R2
  AST_CLEAR_A: assert property (@(posedge clk_a)
    (en_a && rst_a) |=> (dout_a == '0 && !dinv_a)); // R4
  AST_CLEAR_B: assert property (@(posedge clk_b)
    (en_b && rst_b) |=> (dout_b == '0 && !dinv_b)); // R4
endmodule

bind wf_dpram wf_dpram_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_a(clk_a), .en_a(en_a), .we_a(we_a), .rst_a(rst_a), .din_a(din_a),
  .dout_a(dout_a), .dinv_a(dinv_a),
  .clk_b(clk_b), .en_b(en_b), .we_b(we_b), .rst_b(rst_b), .din_b(din_b),
  .dout_b(dout_b), .dinv_b(dinv_b)
);

// File: tb/tb_wf_dpram.sv
`timescale 1ns/1ps
module tb_wf_dpram;
  localparam int DW = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          en_a = 0, we_a = 0, rst_a = 0;
  logic          en_b = 0, we_b = 0, rst_b = 0;
  logic [AW-1:0] addr_a = '0, addr_b = '0;
  logic [DW-1:0] din_a = '0, din_b = '0;
  logic [DW-1:0] dout_a, dout_b;
  logic          dinv_a, dinv_b;

  int n_run = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  wf_dpram #(.DATA_W(DW), .DEPTH(256), .COMMON_CLK(1'b1)) dut (
    .clk_a(clk), .en_a(en_a), .we_a(we_a), .rst_a(rst_a),
    .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a), .dinv_a(dinv_a),
    .clk_b(clk), .en_b(en_b), .we_b(we_b), .rst_b(rst_b),
    .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b), .dinv_b(dinv_b)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic op_a(logic en, logic we, logic rst, logic [AW-1:0] ad, logic [DW-1:0] d);
    en_a = en; we_a = we; rst_a = rst; addr_a = ad; din_a = d;
  endtask

  task automatic op_b(logic en, logic we, logic rst, logic [AW-1:0] ad, logic [DW-1:0] d);
    en_b = en; we_b = we; rst_b = rst; addr_b = ad; din_b = d;
  endtask

  task automatic idle();
    op_a(0, 0, 0, '0, '0);
    op_b(0, 0, 0, '0, '0);
  endtask

  task automatic t_power_up();
    #1;
    chk("R5 dout_a at start", dout_a, 0);
    chk("R5 dinv_b at start", dinv_b, 0);
    idle(); tick(); tick();
    chk("R5 dout_a after idle edges", dout_a, 0);
    chk("R5 dout_b after idle edges", dout_b, 0);
  endtask

  task automatic t_write_read();
    op_a(1, 1, 0, 8'h0F, 16'h1234); tick();
    chk("R2 write echo A", dout_a, 16'h1234);
    chk("R2 writer flag A", dinv_a, 0);
    op_a(0, 0, 0, 8'h00, 0); op_b(1, 0, 0, 8'h0F, 0); tick();
    chk("R1 read B", dout_b, 16'h1234);
    op_b(0, 0, 0, 0, 0); op_a(1, 0, 0, 8'h0F, 0); tick();
    chk("R1 read A", dout_a, 16'h1234);
    idle();
  endtask

  task automatic t_disable();
    op_a(0, 1, 0, 8'h0F, 16'hDEAD); tick();
    chk("R3 hold A while disabled", dout_a, 16'h1234);
    op_a(1, 0, 0, 8'h0E, 0); tick();
    op_a(1, 0, 0, 8'h0F, 0); tick();
    chk("R3 memory untouched", dout_a, 16'h1234);
    idle();
  endtask

  task automatic t_reset();
    op_a(1, 0, 1, 8'h0F, 0); tick();
    chk("R4 reset clears dout", dout_a, 0);
    op_a(1, 1, 1, 8'h20, 16'h5555); tick();
    chk("R4 reset beats write echo", dout_a, 0);
    op_a(1, 0, 0, 8'h20, 0); tick();
    chk("R4 write under reset stored", dout_a, 16'h5555);
    op_a(0, 0, 1, 8'h20, 0); tick();
    chk("R4 reset without enable ignored", dout_a, 16'h5555);
    op_a(1, 0, 0, 8'h0F, 0); tick();
    chk("R4 reset left memory", dout_a, 16'h1234);
    idle();
  endtask

  task automatic t_write_vs_read();
    op_a(1, 1, 0, 8'h30, 16'hAAAA); op_b(1, 0, 0, 8'h30, 0); tick();
    chk("R6 writer A data", dout_a, 16'hAAAA);
    chk("R6 writer A flag", dinv_a, 0);
    chk("R6 reader B flag", dinv_b, 1);
    op_a(0, 0, 0, 0, 0); op_b(1, 0, 0, 8'h30, 0); tick();
    chk("R6 write kept", dout_b, 16'hAAAA);
    chk("R6 later read clean", dinv_b, 0);
    op_b(1, 1, 0, 8'h31, 16'h1111); op_a(1, 0, 0, 8'h31, 0); tick();
    chk("R6 reader A flag", dinv_a, 1);
    chk("R6 writer B flag", dinv_b, 0);
    chk("R6 writer B data", dout_b, 16'h1111);
    idle();
  endtask

  task automatic t_write_vs_write();
    op_a(1, 1, 0, 8'h40, 16'h0101); op_b(1, 1, 0, 8'h40, 16'h0202); tick();
    chk("R7 echo A", dout_a, 16'h0101);
    chk("R7 echo B", dout_b, 16'h0202);
    idle(); op_a(1, 0, 0, 8'h40, 0); tick();
    chk("R7 corrupt read A", dinv_a, 1);
    idle(); op_b(1, 0, 0, 8'h40, 0); tick();
    chk("R7 corrupt read B", dinv_b, 1);
    idle(); op_a(1, 1, 0, 8'h40, 16'h7777); tick();
    idle(); op_b(1, 0, 0, 8'h40, 0); tick();
    chk("R8 repaired data", dout_b, 16'h7777);
    chk("R8 repaired flag", dinv_b, 0);
    idle();
  endtask

  task automatic t_read_read();
    op_b(1, 1, 0, 8'h50, 16'h3333); tick();
    idle(); op_a(1, 0, 0, 8'h50, 0); op_b(1, 0, 0, 8'h50, 0); tick();
    chk("R9 data A", dout_a, 16'h3333);
    chk("R9 data B", dout_b, 16'h3333);
    chk("R9 flag A", dinv_a, 0);
    chk("R9 flag B", dinv_b, 0);
    idle();
  endtask

  task automatic t_stale();
    op_a(1, 1, 0, 8'h60, 16'h1000); tick();
    idle(); op_b(1, 0, 0, 8'h60, 0); tick();
    chk("R10 first read B", dout_b, 16'h1000);
    idle(); op_a(1, 1, 0, 8'h60, 16'h2000); tick();
    chk("R10 B not updated", dout_b, 16'h1000);
    idle(); op_b(1, 0, 0, 8'h60, 0); tick();
    chk("R10 B next read", dout_b, 16'h2000);
    idle();
  endtask

  task automatic t_diff_addr();
    op_a(1, 1, 0, 8'h70, 16'hBEEF); op_b(1, 1, 0, 8'h71, 16'hCAFE); tick();
    chk("R11 flag A", dinv_a, 0);
    chk("R11 flag B", dinv_b, 0);
    op_a(1, 0, 0, 8'h71, 0); op_b(1, 0, 0, 8'h70, 0); tick();
    chk("R11 A reads B word", dout_a, 16'hCAFE);
    chk("R11 B reads A word", dout_b, 16'hBEEF);
    chk("R11 no flag on read A", dinv_a, 0);
    idle();
  endtask

  initial begin
    t_power_up();
    t_write_read();
    t_disable();
    t_reset();
    t_write_vs_read();
    t_write_vs_write();
    t_read_read();
    t_stale();
    t_diff_addr();
    tick();
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_run++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule